// File: doc/BRIEF.md
# Redundant Lane Compare and Restart-Point Unit

This block sits at the memory-access stage of a processor pipeline. The earlier part of the pipeline runs as two redundant lanes. The unit captures each lane's execution result into stage registers that are triplicated. The first lane feeds copies 0 and 2, and the second lane feeds copy 1 alone. Each cycle the unit compares copy 0 with copy 1. If the results or their valid flags disagree, the instruction is marked corrupted, and any data-bus request it carries is suppressed. Because nothing unsafe has left the core at that point, detecting the fault is enough.

A corrupted instruction causes a one-cycle flush in the next cycle. The flush comes with a redirect address read from a restart-point register. That register is held as three copies, and each copy is read through its own majority voter. Each voter output feeds one downstream lane and also refreshes its own copy. An instruction that commits cleanly loads the address of the next instruction into the register. Because of this, no instruction address has to travel down the pipeline under protection. A test port can flip a single bit in one chosen copy to exercise the voting.

Top module: `lane_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `flush_o` and `corrupt_o` are 0, and `redirect_addr_o` and all three voted outputs equal the `RESET_ADDR` parameter.
- R2: Lane results presented with their valid flags in cycle N are compared in cycle N+1. Equal results with both flags set give `corrupt_o`=0, and `bus_req_o` then follows `bus_req_i`.
- R3: In cycle N+1, `corrupt_o` is 1 if exactly one lane was valid in cycle N, or if both were valid with different results. While `corrupt_o` is 1, `bus_req_o` is 0 whatever `bus_req_i` is.
- R4: `flush_o` is 1 for exactly the one cycle after a cycle with `corrupt_o`=1. In that cycle `redirect_addr_o` carries the restart point.
- R5: Lane inputs presented in a cycle with `corrupt_o`=1 or `flush_o`=1 are discarded and cannot raise `corrupt_o`. `bus_req_o` is 0 while `flush_o` is 1.
- R6: A `commit_i` pulse in a cycle where the stage holds a valid, uncorrupted instruction loads `commit_addr_i`. The new value appears on `redirect_addr_o` and on the voted outputs in the next cycle.
- R7: `commit_i` has no effect when the stage is empty, or when `corrupt_o` is 1 in the same cycle. The restart point then keeps its value.
- R8: When `inj_en_i` is 1, bit `inj_bit_i` of copy `inj_copy_i` (0, 1 or 2; the value 3 selects none) is inverted at the clock edge. The voted outputs do not change. Each copy is rewritten from its voter on the following edge, so single flips in different copies on consecutive cycles are also masked.
- R9: The three voted outputs are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lane0_valid_i | input | 1 | First lane holds a result |
| lane0_result_i | input | DATA_W | First lane result (feeds copies 0 and 2) |
| lane1_valid_i | input | 1 | Second lane holds a result |
| lane1_result_i | input | DATA_W | Second lane result (feeds copy 1) |
| bus_req_i | input | 1 | Bus request intent of the instruction in the stage |
| commit_i | input | 1 | Instruction in the stage commits |
| commit_addr_i | input | ADDR_W | Address of the next instruction |
| inj_en_i | input | 1 | Fault injection enable |
| inj_copy_i | input | 2 | Copy to disturb (3 = none) |
| inj_bit_i | input | $clog2(ADDR_W) | Bit to invert |
| bus_req_o | output | 1 | Gated bus request |
| corrupt_o | output | 1 | Instruction in the stage is corrupted |
| flush_o | output | 1 | Pipeline flush, one cycle |
| redirect_addr_o | output | ADDR_W | Fetch redirect address |
| voted0_o | output | ADDR_W | Voter 0 output to lane 0 |
| voted1_o | output | ADDR_W | Voter 1 output to lane 1 |
| voted2_o | output | ADDR_W | Voter 2 output to lane 2 |

## Verification
The bench builds the unit with DATA_W=16, ADDR_W=12, RESET_ADDR=12'h100 and SCRUB=1. With a 12-bit address, injections can cover every bit position of every copy in a few hundred cycles. With SCRUB=1 the copies refresh from their voters, so flips into different copies on back-to-back cycles become a real test of the repair path. The 16-bit results keep the random phase dense with both matches and deliberate mismatches.

// File: rtl/lgd_pkg.sv
package lgd_pkg;
   localparam int unsigned NCOPY = 3;
   localparam int unsigned NO_COPY = 3;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/lgd_voter.sv
module lgd_voter #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] y_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y_o[i] = lgd_pkg::maj3(a_i[i], b_i[i], c_i[i]);
   end
endmodule

// File: rtl/lgd_tmr_reg.sv
module lgd_tmr_reg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] INIT = '0,
   parameter bit SCRUB = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [2:0]             we_i,
   input  logic [W-1:0]           wdata_i,
   input  logic [2:0][W-1:0]      flip_i,
   output logic [2:0][W-1:0]      vote_o
);
   logic [2:0][W-1:0] copy_q;

   for (genvar k = 0; k < 3; k++) begin : g_copy
      lgd_voter #(.W(W)) u_vote (
         .a_i(copy_q[0]),
         .b_i(copy_q[1]),
         .c_i(copy_q[2]),
         .y_o(vote_o[k])
      );

      logic [W-1:0] keep;
      if (SCRUB) begin : g_scrub
         assign keep = vote_o[k];
      end else begin : g_hold
         assign keep = copy_q[k];
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            copy_q[k] <= INIT;
         end else begin
            copy_q[k] <= (we_i[k] ? wdata_i : keep) ^ flip_i[k];
         end
      end
   end
endmodule

// File: rtl/lgd_lane_stage.sv
module lgd_lane_stage #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              squash_i,
   input  logic              lane0_valid_i,
   input  logic [DATA_W-1:0] lane0_result_i,
   input  logic              lane1_valid_i,
   input  logic [DATA_W-1:0] lane1_result_i,
   output logic [2:0]        vld_o,
   output logic              mismatch_o
);
   logic [2:0]        vld_q;
   logic [DATA_W-1:0] res_t0_q;
   logic [DATA_W-1:0] res_t1_q;
   logic [2:0]        vld_in;

   // copy 0 and 2 come from the first lane, copy 1 from the second
   assign vld_in = {lane0_valid_i, lane1_valid_i, lane0_valid_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vld_q <= '0;
      end else begin
         vld_q <= squash_i ? 3'b000 : vld_in;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         res_t0_q <= '0;
         res_t1_q <= '0;
      end else begin
         if (lane0_valid_i) res_t0_q <= lane0_result_i;
         if (lane1_valid_i) res_t1_q <= lane1_result_i;
      end
   end

   assign vld_o      = vld_q;
   assign mismatch_o = (vld_q[0] != vld_q[1]) || (vld_q[0] && (res_t0_q != res_t1_q));
endmodule

// File: rtl/lane_guard.sv
module lane_guard #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   parameter bit SCRUB = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       lane0_valid_i,
   input  logic [DATA_W-1:0]          lane0_result_i,
   input  logic                       lane1_valid_i,
   input  logic [DATA_W-1:0]          lane1_result_i,
   input  logic                       bus_req_i,
   input  logic                       commit_i,
   input  logic [ADDR_W-1:0]          commit_addr_i,
   input  logic                       inj_en_i,
   input  logic [1:0]                 inj_copy_i,
   input  logic [$clog2(ADDR_W)-1:0]  inj_bit_i,
   output logic                       bus_req_o,
   output logic                       corrupt_o,
   output logic                       flush_o,
   output logic [ADDR_W-1:0]          redirect_addr_o,
   output logic [ADDR_W-1:0]          voted0_o,
   output logic [ADDR_W-1:0]          voted1_o,
   output logic [ADDR_W-1:0]          voted2_o
);
   localparam int unsigned NC = lgd_pkg::NCOPY;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   if (DATA_W < 1) begin : g_bad_data
      $error("lane_guard: DATA_W must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lane_guard: ADDR_W must be at least 2");
   end

   logic [2:0]             vld;
   logic                   mismatch;
   logic                   flush_q;
   logic                   squash;
   logic [2:0]             we;
   logic [2:0][ADDR_W-1:0] flip;
   logic [2:0][ADDR_W-1:0] vote;

   assign squash = mismatch | flush_q;

   lgd_lane_stage #(.DATA_W(DATA_W)) u_stage (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .squash_i      (squash),
      .lane0_valid_i (lane0_valid_i),
      .lane0_result_i(lane0_result_i),
      .lane1_valid_i (lane1_valid_i),
      .lane1_result_i(lane1_result_i),
      .vld_o         (vld),
      .mismatch_o    (mismatch)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) flush_q <= 1'b0;
      else         flush_q <= mismatch;
   end

   for (genvar k = 0; k < NC; k++) begin : g_ctl
      // each copy is written under its own lane's valid flag
      assign we[k]   = commit_i & vld[k] & ~mismatch;
      assign flip[k] = (inj_en_i && (inj_copy_i == 2'(k))) ? (ONE << inj_bit_i) : '0;
   end

   lgd_tmr_reg #(.W(ADDR_W), .INIT(RESET_ADDR), .SCRUB(SCRUB)) u_rp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .wdata_i(commit_addr_i),
      .flip_i (flip),
      .vote_o (vote)
   );

   assign corrupt_o       = mismatch;
   assign flush_o         = flush_q;
   assign bus_req_o       = bus_req_i & ~mismatch & ~flush_q;
   assign redirect_addr_o = vote[0];
   assign voted0_o        = vote[0];
   assign voted1_o        = vote[1];
   assign voted2_o        = vote[2];
endmodule

// File: rtl/lane_guard_chk.sv
module lane_guard_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              commit_i,
   input logic              bus_req_o,
   input logic              corrupt_o,
   input logic              flush_o,
   input logic [ADDR_W-1:0] redirect_addr_o,
   input logic [ADDR_W-1:0] voted0_o,
   input logic [ADDR_W-1:0] voted1_o,
   input logic [ADDR_W-1:0] voted2_o
);
   a_r3_bus_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corrupt_o |-> !bus_req_o);
   a_r4_flush_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corrupt_o |=> flush_o);
   a_r4_flush_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |=> !flush_o);
   a_r5_quiet_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (!corrupt_o && !bus_req_o));
   a_r7_hold_on_corrupt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corrupt_o |=> $stable(redirect_addr_o));
   a_r7_hold_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(redirect_addr_o));
   a_r9_voters_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (voted0_o == voted1_o) && (voted1_o == voted2_o));
endmodule

bind lane_guard lane_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .commit_i       (commit_i),
   .bus_req_o      (bus_req_o),
   .corrupt_o      (corrupt_o),
   .flush_o        (flush_o),
   .redirect_addr_o(redirect_addr_o),
   .voted0_o       (voted0_o),
   .voted1_o       (voted1_o),
   .voted2_o       (voted2_o)
);

// File: tb/sim_lane_guard.sv
module sim_lane_guard;
   localparam int PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam logic [AW-1:0] RST_A = 12'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l0v = 0, l1v = 0, bus = 0, cmt = 0, inj = 0;
   logic [DW-1:0] l0r = '0, l1r = '0;
   logic [AW-1:0] caddr = '0;
   logic [1:0] icopy = 2'd3;
   logic [3:0] ibit = '0;
   logic bus_o, cor_o, fl_o;
   logic [AW-1:0] red_o, v0_o, v1_o, v2_o;

   int vectors = 0;
   int fails = 0;
   string req = "R1";

   // reference state
   bit m_v0 = 0, m_v1 = 0, m_fl = 0;
   logic [DW-1:0] m_r0 = '0, m_r1 = '0;
   logic [AW-1:0] m_rp = RST_A;

   always #(PERIOD/2) clk = ~clk;

   lane_guard #(.DATA_W(DW), .ADDR_W(AW), .RESET_ADDR(RST_A), .SCRUB(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .lane0_valid_i(l0v), .lane0_result_i(l0r),
      .lane1_valid_i(l1v), .lane1_result_i(l1r),
      .bus_req_i(bus), .commit_i(cmt), .commit_addr_i(caddr),
      .inj_en_i(inj), .inj_copy_i(icopy), .inj_bit_i(ibit),
      .bus_req_o(bus_o), .corrupt_o(cor_o), .flush_o(fl_o),
      .redirect_addr_o(red_o), .voted0_o(v0_o), .voted1_o(v1_o), .voted2_o(v2_o)
   );

   task automatic chk1(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // inputs already driven; compare outputs, then advance model across the edge
   task automatic cycle();
      bit c;
      bit n_v0, n_v1, n_fl;
      logic [DW-1:0] n_r0, n_r1;
      logic [AW-1:0] n_rp;
      #(PERIOD/4);
      c = (m_v0 != m_v1) || (m_v0 && (m_r0 != m_r1));
      if (!rst_n) c = 0;
      vectors++;
      chk1("corrupt", AW'(cor_o), AW'(c));
      chk1("flush", AW'(fl_o), AW'(m_fl));
      chk1("bus_req", AW'(bus_o), AW'(bus & ~c & ~m_fl));
      chk1("redirect", red_o, m_rp);
      chk1("voted0", v0_o, m_rp);
      chk1("voted1", v1_o, m_rp);
      chk1("voted2", v2_o, m_rp);
      if (!rst_n) begin
         n_v0 = 0; n_v1 = 0; n_fl = 0; n_r0 = '0; n_r1 = '0; n_rp = RST_A;
      end else begin
         n_v0 = (c || m_fl) ? 1'b0 : l0v;
         n_v1 = (c || m_fl) ? 1'b0 : l1v;
         n_r0 = l0v ? l0r : m_r0;
         n_r1 = l1v ? l1r : m_r1;
         n_fl = c;
         n_rp = (cmt && m_v0 && !c) ? caddr : m_rp;
      end
      @(posedge clk);
      m_v0 = n_v0; m_v1 = n_v1; m_fl = n_fl; m_r0 = n_r0; m_r1 = n_r1; m_rp = n_rp;
      @(negedge clk);
   endtask

   task automatic drive(input bit a_v, input logic [DW-1:0] a_r, input bit b_v,
                        input logic [DW-1:0] b_r, input bit b, input bit cm,
                        input logic [AW-1:0] ad);
      l0v = a_v; l0r = a_r; l1v = b_v; l1r = b_r; bus = b; cmt = cm; caddr = ad;
      inj = 0; icopy = 2'd3;
   endtask

   initial begin
      #(PERIOD*200000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      req = "R1";
      for (int i = 0; i < 3; i++) cycle();
      rst_n = 1'b1;
      cycle();

      // R2: matched pairs, bus request passes the following cycle
      req = "R2";
      drive(1, 16'h1234, 1, 16'h1234, 0, 0, 0); cycle();
      drive(1, 16'hBEEF, 1, 16'hBEEF, 1, 0, 0); cycle();
      drive(0, 16'h0000, 0, 16'h5555, 1, 0, 0); cycle();
      drive(0, 0, 0, 0, 1, 0, 0); cycle();

      // R6: clean commit loads the restart point
      req = "R6";
      drive(1, 16'h0042, 1, 16'h0042, 0, 0, 0); cycle();
      drive(0, 0, 0, 0, 1, 1, 12'hA5C); cycle();
      drive(0, 0, 0, 0, 0, 0, 0); cycle();

      // R3: result mismatch blocks the bus; R7: same-cycle commit ignored
      req = "R3";
      drive(1, 16'h0F0F, 1, 16'h0F0E, 0, 0, 0); cycle();
      req = "R7";
      drive(1, 16'h1111, 1, 16'h2222, 1, 1, 12'h3C3); cycle();   // R5: squashed input
      req = "R4";
      drive(0, 16'h7777, 1, 16'h7777, 1, 1, 12'h0AA); cycle();   // R5: flush cycle
      req = "R5";
      drive(0, 0, 0, 0, 1, 0, 0); cycle();

      // R3: valid-flag disagreement
      req = "R3";
      drive(1, 16'h00AA, 0, 16'h00AA, 0, 0, 0); cycle();
      drive(0, 0, 0, 0, 1, 0, 0); cycle();
      drive(0, 0, 1, 16'h0001, 0, 0, 0); cycle();
      drive(0, 0, 0, 0, 0, 0, 0); cycle();
      cycle();

      // R7: commit with empty stage
      req = "R7";
      drive(0, 0, 0, 0, 0, 1, 12'h777); cycle();
      drive(0, 0, 0, 0, 0, 0, 0); cycle();

      // R8: single flips, walking across copies on consecutive cycles
      req = "R8";
      for (int b = 0; b < AW; b++) begin
         for (int k = 0; k < 3; k++) begin
            drive(0, 0, 0, 0, 0, 0, 0);
            inj = 1; icopy = 2'(k); ibit = 4'(b);
            cycle();
         end
      end
      drive(1, 16'h0303, 1, 16'h0303, 0, 0, 0); cycle();
      drive(0, 0, 0, 0, 0, 1, 12'h5A1); inj = 1; icopy = 2'd1; ibit = 4'd0; cycle();
      drive(0, 0, 0, 0, 0, 0, 0); inj = 1; icopy = 2'd2; ibit = 4'd11; cycle();
      drive(0, 0, 0, 0, 0, 0, 0); cycle();

      // R9 plus mixed traffic
      req = "R9";
      for (int n = 0; n < 600; n++) begin
         logic [DW-1:0] r;
         int sel;
         r = DW'($urandom);
         sel = int'($urandom_range(0, 9));
         drive(sel != 0, r, sel != 1, (sel == 2) ? r ^ DW'(1 << (n % DW)) : r,
               1'($urandom), 1'($urandom), AW'($urandom));
         inj = 1'($urandom); icopy = 2'($urandom); ibit = 4'($urandom_range(0, AW-1));
         cycle();
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule